// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block is a periodic down-counter for a real-time-clock style subsystem. Software writes a start value n, picks one of four tick rates and enables the timer. The counter then counts down from n on the chosen tick. When it runs out it reloads n and carries on. Each time it runs out it sets a sticky expiry flag, which stays set until software clears it with a write. The read port always shows the remaining count as it changes, not the start value.

The tick rates are built inside the block from a base clock. A divider chain gives a fast tick (nominally 4.096 kHz when the base clock is 32.768 kHz), a 64 Hz reference, a 1 Hz tick and a once-per-minute tick. When the timer starts, the seconds and minutes dividers are realigned so that the first slow tick comes within one 64 Hz period.

The interrupt output is active-low and has two forms. In pulse form it goes low for one 64 Hz period at every expiry. In level form it mirrors the flag. An interrupt-enable input masks the output and leaves the flag alone.

Top module: `cdt_timer_top`

## Requirements
- R1: `tmr_sel` picks the tick source. The codes are 0 = fast tick (CLK_PER_FAST base cycles), 1 = 64 Hz reference (fast period times FAST_PER_64), 2 = seconds (64 Hz period times SLOW_PER_SEC) and 3 = minutes (seconds period times SEC_PER_MIN).
- R2: An expiry sets `tmr_flag`. The flag stays set until a cycle with `flag_wr`=1 and `flag_wr_val`=0 clears it. A write with `flag_wr_val`=1 leaves the flag unchanged.
- R3: The timer is stopped when `tmr_en`=0 or the start value is 0. While stopped, `tmr_count` reads 0 and the timer never sets the flag.
- R4: Let P be the source period. From the clock edge that samples the timer starting to the expiry edge, the first period lasts between n·P+1 and n·P+P base cycles for sources 0 and 1. For sources 2 and 3 it lasts between n·P+1 and n·P+P64 base cycles, where P64 is the 64 Hz period.
- R5: After the first expiry the counter reloads n by itself. Every later period lasts exactly n·P base cycles for as long as the timer stays enabled.
- R6: `tmr_count` shows the live remaining count. It reads n in the cycle after a start and in the cycle after every expiry, and it drops by one on each source tick in between.
- R7: In pulse form (`irq_level`=0), `irq_n` goes low in the cycle after an expiry and stays low for exactly P64 base cycles. A new expiry restarts the pulse.
- R8: In level form (`irq_level`=1), `irq_n` is the inverse of `tmr_flag`.
- R9: With `irq_en`=0, `irq_n` stays high and `tmr_flag` is unaffected.
- R10: If an expiry and a flag clear fall in the same cycle, the flag ends up set.
- R11: While reset is active, `tmr_count` reads 0, `tmr_flag` reads 0 and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock that all tick rates are derived from |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_en | input | 1 | Timer enable |
| tmr_sel | input | 2 | Tick source code (see R1) |
| tmr_start | input | CW | Start and reload value n; 0 stops the timer |
| irq_en | input | 1 | Interrupt output enable |
| irq_level | input | 1 | 1 = level form, 0 = pulse form |
| flag_wr | input | 1 | Flag write strobe |
| flag_wr_val | input | 1 | Written flag bit: 0 clears, 1 keeps |
| tmr_count | output | CW | Live remaining count |
| tmr_flag | output | 1 | Sticky expiry flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench measures the first period against the R4 windows on every source. A design that forgets to realign the slow dividers would miss the seconds and minutes windows. A design that counts the start-cycle tick would come in one tick short. It then times later periods exactly and reads the live count right after reload and one tick later, which catches off-by-one reloads and a read path that returns n. It also lands a flag clear on the exact expiry cycle. A design that lets the clear win would read the flag as 0. Finally it checks that a write of 1 leaves the flag alone, that the enable masks the output while the flag stays set, and that a start value of 0 never raises the flag.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_64   = 2'd1,
    SRC_SEC  = 2'd2,
    SRC_MIN  = 2'd3
  } src_sel_e;

  localparam int unsigned NUM_SRC = 4;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/cdt_rst_sync.sv
module cdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
#(
  parameter int unsigned CLK_PER_FAST = 8,
  parameter int unsigned FAST_PER_64  = 64,
  parameter int unsigned SLOW_PER_SEC = 64,
  parameter int unsigned SEC_PER_MIN  = 60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase_rst,
  output logic [NUM_SRC-1:0] tick
);

  localparam int unsigned FW   = $clog2(CLK_PER_FAST + 1);
  localparam int unsigned MAXR = max3(FAST_PER_64, SLOW_PER_SEC, SEC_PER_MIN);
  localparam int unsigned SW   = $clog2(MAXR + 1);
  localparam int unsigned RAT [3] = '{FAST_PER_64, SLOW_PER_SEC, SEC_PER_MIN};

  logic [NUM_SRC-1:0] tick_w;
  logic [FW-1:0]      fast_q, fast_d;
  logic               fast_wrap;

  // base clock -> fast tick
  assign fast_wrap = (fast_q == FW'(CLK_PER_FAST - 1));
  assign tick_w[0] = fast_wrap;

  always_comb begin
    if (fast_wrap) fast_d = '0;
    else           fast_d = fast_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fast_q <= '0;
    else        fast_q <= fast_d;
  end

  // cascaded dividers: 64 Hz (free running), seconds and minutes (realigned at start)
  for (genvar i = 0; i < 3; i++) begin : g_stage
    logic [SW-1:0] div_q, div_d;
    logic          wrap;

    assign wrap        = (div_q == SW'(RAT[i] - 1));
    assign tick_w[i+1] = tick_w[i] & wrap;

    if (i == 0) begin : g_free
      always_comb begin
        div_d = div_q;
        if (tick_w[i]) div_d = wrap ? '0 : div_q + 1'b1;
      end
    end else begin : g_align
      always_comb begin
        div_d = div_q;
        if (phase_rst)      div_d = SW'(RAT[i] - 1);
        else if (tick_w[i]) div_d = wrap ? '0 : div_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_d;
    end
  end

  assign tick = tick_w;

  if (CLK_PER_FAST > 1) begin : g_fast_chk
    assert_fast_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_w[0] |=> !tick_w[0]);
  end

  // after a start the next 64 Hz tick also produces a seconds and a minutes tick
  assert_sec_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |=> (tick_w[2] == tick_w[1]));
  assert_min_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |=> (tick_w[3] == tick_w[1]));

endmodule

// File: rtl/cdt_count.sv
module cdt_count
  import cdt_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [CW-1:0]      start_val,
  input  logic [1:0]         sel,
  input  logic [NUM_SRC-1:0] tick,
  output logic [CW-1:0]      count,
  output logic               expire,
  output logic               start
);

  logic          run, run_q, run_d;
  logic          arm_q, arm_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          src_tick;

  assign run   = enable & (start_val != '0);
  assign start = run & ~run_q;

  always_comb begin
    case (src_sel_e'(sel))
      SRC_FAST: src_tick = tick[0];
      SRC_64:   src_tick = tick[1];
      SRC_SEC:  src_tick = tick[2];
      SRC_MIN:  src_tick = tick[3];
      default:  src_tick = 1'b0;
    endcase
  end

  always_comb begin
    run_d  = run;
    arm_d  = arm_q;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (!run) begin
      cnt_d = '0;
      arm_d = 1'b0;
    end else if (start) begin
      cnt_d = start_val;
      arm_d = 1'b1;
    end else if (src_tick) begin
      if (arm_q) begin
        arm_d = 1'b0;
      end else if (cnt_q <= CW'(1)) begin
        cnt_d  = start_val;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      arm_q <= arm_d;
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == $past(start_val)));
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == $past(start_val)));
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));
  assert_live_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run) |-> (count != '0));

endmodule

// File: rtl/cdt_irq.sv
module cdt_irq #(
  parameter int unsigned PULSE_CYC = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic flag_wr,
  input  logic flag_wr_val,
  input  logic irq_en,
  input  logic irq_level,
  output logic flag,
  output logic irq_n
);

  localparam int unsigned PW = $clog2(PULSE_CYC + 1);

  logic          flag_q, flag_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          pulse_on;

  always_comb begin
    flag_d = flag_q;
    if (expire)       flag_d = 1'b1;
    else if (flag_wr) flag_d = flag_q & flag_wr_val;
  end

  always_comb begin
    pulse_d = pulse_q;
    if (expire)              pulse_d = PW'(PULSE_CYC);
    else if (pulse_q != '0)  pulse_d = pulse_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= '0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_on = (pulse_q != '0);
  assign flag     = flag_q;
  assign irq_n    = ~(irq_en & (irq_level ? flag_q : pulse_on));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(flag_wr && !flag_wr_val)) |=> flag);
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire && flag_wr && !flag_wr_val) |=> !flag);
  assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pulse_on);

endmodule

// File: rtl/cdt_timer_top.sv
module cdt_timer_top
  import cdt_pkg::*;
#(
  parameter int unsigned CW           = 8,
  parameter int unsigned CLK_PER_FAST = 8,
  parameter int unsigned FAST_PER_64  = 64,
  parameter int unsigned SLOW_PER_SEC = 64,
  parameter int unsigned SEC_PER_MIN  = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_en,
  input  logic [1:0]    tmr_sel,
  input  logic [CW-1:0] tmr_start,
  input  logic          irq_en,
  input  logic          irq_level,
  input  logic          flag_wr,
  input  logic          flag_wr_val,
  output logic [CW-1:0] tmr_count,
  output logic          tmr_flag,
  output logic          irq_n
);

  localparam int unsigned PULSE_CYC = CLK_PER_FAST * FAST_PER_64;

  logic               rst_sync_n;
  logic [NUM_SRC-1:0] tick;
  logic               expire;
  logic               start;

  cdt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cdt_prescaler #(
    .CLK_PER_FAST (CLK_PER_FAST),
    .FAST_PER_64  (FAST_PER_64),
    .SLOW_PER_SEC (SLOW_PER_SEC),
    .SEC_PER_MIN  (SEC_PER_MIN)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .phase_rst (start),
    .tick      (tick)
  );

  cdt_count #(
    .CW (CW)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (tmr_en),
    .start_val (tmr_start),
    .sel       (tmr_sel),
    .tick      (tick),
    .count     (tmr_count),
    .expire    (expire),
    .start     (start)
  );

  cdt_irq #(
    .PULSE_CYC (PULSE_CYC)
  ) u_irq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .expire      (expire),
    .flag_wr     (flag_wr),
    .flag_wr_val (flag_wr_val),
    .irq_en      (irq_en),
    .irq_level   (irq_level),
    .flag        (tmr_flag),
    .irq_n       (irq_n)
  );

endmodule

// File: tb/tb_cdt_timer_top.sv
module tb_cdt_timer_top;

  localparam int CPF = 2;
  localparam int F64 = 4;
  localparam int SPS = 4;
  localparam int SPM = 3;
  localparam int CW  = 8;
  localparam int P64 = CPF * F64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tmr_en;
  logic [1:0]    tmr_sel;
  logic [CW-1:0] tmr_start;
  logic          irq_en, irq_level, flag_wr, flag_wr_val;
  logic [CW-1:0] tmr_count;
  logic          tmr_flag, irq_n;

  int cyc    = 0;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cdt_timer_top #(
    .CW (CW), .CLK_PER_FAST (CPF), .FAST_PER_64 (F64),
    .SLOW_PER_SEC (SPS), .SEC_PER_MIN (SPM)
  ) dut (
    .clk (clk), .rst_n (rst_n), .tmr_en (tmr_en), .tmr_sel (tmr_sel),
    .tmr_start (tmr_start), .irq_en (irq_en), .irq_level (irq_level),
    .flag_wr (flag_wr), .flag_wr_val (flag_wr_val), .tmr_count (tmr_count),
    .tmr_flag (tmr_flag), .irq_n (irq_n)
  );

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int src_period(input int sel);
    case (sel)
      0:       return CPF;
      1:       return P64;
      2:       return P64 * SPS;
      default: return P64 * SPS * SPM;
    endcase
  endfunction

  function automatic int first_hi(input int sel, input int n);
    if (sel < 2) return n * src_period(sel) + src_period(sel);
    return n * src_period(sel) + P64;
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input string what, input int act,
                           input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_fall(output int at);
    bit prev;
    prev = irq_n;
    at   = -1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (prev && !irq_n) begin
        at = cyc;
        break;
      end
      prev = irq_n;
    end
  endtask

  task automatic wait_rise(output int at);
    bit prev;
    prev = irq_n;
    at   = -1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (!prev && irq_n) begin
        at = cyc;
        break;
      end
      prev = irq_n;
    end
  endtask

  task automatic stop_and_clear();
    tmr_en = 1'b0;
    wait_cyc(P64 + 2);
    flag_wr = 1'b1; flag_wr_val = 1'b0;
    wait_cyc(1);
    flag_wr = 1'b0;
    wait_cyc(1);
  endtask

  task automatic run_case(input int sel, input int n, input int nper);
    int t0, f, fprev, r, p;
    p = src_period(sel);
    irq_level = 1'b0; irq_en = 1'b1;
    tmr_sel = 2'(sel); tmr_start = CW'(n);
    t0 = cyc;
    tmr_en = 1'b1;
    wait_cyc(1);
    check_eq("R6", "count right after start", int'(tmr_count), n);
    wait_fall(f);
    check_rng("R4 R1", "first period", f - (t0 + 1), n * p + 1, first_hi(sel, n));
    if (f >= 0) begin
      check_eq("R2", "flag after expiry", int'(tmr_flag), 1);
      check_eq("R6", "count after reload", int'(tmr_count), n);
      if (n >= 2) begin
        wait_cyc(p);
        check_eq("R6", "count one tick after reload", int'(tmr_count), n - 1);
      end
      for (int k = 0; k < nper; k++) begin
        fprev = f;
        wait_fall(f);
        check_eq("R5 R1", "period", f - fprev, n * p);
        if (f < 0) break;
        if (n * p > P64) begin
          wait_rise(r);
          check_eq("R7", "pulse width", r - f, P64);
        end
      end
    end
    stop_and_clear();
  endtask

  initial begin
    int f, sel, n;
    int unsigned seed_init;
    seed_init = $urandom(32'd20517);
    rst_n = 1'b0; tmr_en = 1'b0; tmr_sel = 2'd0; tmr_start = '0;
    irq_en = 1'b0; irq_level = 1'b0; flag_wr = 1'b0; flag_wr_val = 1'b1;
    wait_cyc(4);
    check_eq("R11", "count in reset", int'(tmr_count), 0);
    check_eq("R11", "flag in reset", int'(tmr_flag), 0);
    check_eq("R11", "irq_n in reset", int'(irq_n), 1);
    rst_n = 1'b1;
    wait_cyc(4);

    // R3: zero start value and disabled timer
    tmr_start = '0; tmr_en = 1'b1; irq_en = 1'b1; irq_level = 1'b1;
    wait_cyc(300);
    check_eq("R3", "flag with n=0", int'(tmr_flag), 0);
    check_eq("R3", "count with n=0", int'(tmr_count), 0);
    check_eq("R3", "irq_n with n=0", int'(irq_n), 1);
    tmr_start = CW'(5); tmr_en = 1'b0;
    wait_cyc(40);
    check_eq("R3", "count while disabled", int'(tmr_count), 0);
    check_eq("R3", "flag while disabled", int'(tmr_flag), 0);
    tmr_en = 1'b1;
    wait_cyc(3);
    tmr_start = '0;
    wait_cyc(2);
    check_eq("R3", "count after n set to 0", int'(tmr_count), 0);
    wait_cyc(100);
    check_eq("R3", "no flag after n set to 0", int'(tmr_flag), 0);
    tmr_en = 1'b0;
    wait_cyc(2);

    // directed cases over every source
    run_case(0, 5, 3);
    run_case(0, 255, 1);
    run_case(1, 3, 2);
    run_case(2, 1, 2);
    run_case(2, 2, 2);
    run_case(3, 2, 1);

    // random cases on the fast sources
    for (int k = 0; k < 8; k++) begin
      sel = int'($urandom_range(0, 1));
      n = (sel == 0) ? int'($urandom_range(5, 12)) : int'($urandom_range(2, 6));
      run_case(sel, n, 2);
    end

    // R2 and R10: write-1 keeps, write-0 clears, expiry beats a clear
    irq_level = 1'b0; irq_en = 1'b1; tmr_sel = 2'd1; tmr_start = CW'(2);
    tmr_en = 1'b1;
    wait_fall(f);
    wait_cyc(3);
    flag_wr = 1'b1; flag_wr_val = 1'b1;
    wait_cyc(1);
    flag_wr = 1'b0;
    check_eq("R2", "flag after writing 1", int'(tmr_flag), 1);
    flag_wr = 1'b1; flag_wr_val = 1'b0;
    wait_cyc(1);
    flag_wr = 1'b0;
    check_eq("R2", "flag after writing 0", int'(tmr_flag), 0);
    wait_cyc(10);
    flag_wr = 1'b1; flag_wr_val = 1'b0;
    wait_cyc(1);
    flag_wr = 1'b0;
    check_eq("R10", "flag when clear meets expiry", int'(tmr_flag), 1);
    check_eq("R7", "pulse on that expiry", int'(irq_n), 0);
    stop_and_clear();
    check_eq("R2", "flag after final clear", int'(tmr_flag), 0);

    // R8 and R9: level form and masking
    irq_level = 1'b1; irq_en = 1'b1; tmr_sel = 2'd1; tmr_start = CW'(3);
    tmr_en = 1'b1;
    wait_cyc(1);
    check_eq("R8", "irq_n before expiry", int'(irq_n), 1);
    for (int k = 0; k < 200; k++) begin
      if (tmr_flag) break;
      wait_cyc(1);
    end
    check_eq("R2", "flag raised in level test", int'(tmr_flag), 1);
    check_eq("R8", "irq_n follows flag", int'(irq_n), 0);
    irq_en = 1'b0;
    wait_cyc(1);
    check_eq("R9", "irq_n masked", int'(irq_n), 1);
    check_eq("R9", "flag kept while masked", int'(tmr_flag), 1);
    irq_en = 1'b1;
    wait_cyc(1);
    check_eq("R8", "irq_n after unmask", int'(irq_n), 0);
    stop_and_clear();
    check_eq("R8", "irq_n after clear", int'(irq_n), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule